// File: doc/BRIEF.md
# Shared Forward/Inverse AES Column Mixer

This block applies the AES column-mixing transform to a 128-bit cipher state in either direction. The state is treated as four 32-bit columns, all mixed in parallel. One bank of forward mixing logic serves both directions. In inverse mode, each column first goes through a light pre-multiplication by the polynomial 04·x^2 + 05. The forward mixer then turns that product into the exact inverse transform. Multiplication by that polynomial followed by the forward polynomial 03·x^3 + 01·x^2 + 01·x + 02 gives the inverse polynomial 0b·x^3 + 0d·x^2 + 09·x + 0e modulo x^4 + 1.

A round datapath presents a state with `in_vld` high and picks the direction with `dec_mode`. One clock later the mixed state appears on `state_o`, and `out_vld` is high.

Top module: `mixcol_shared`

## Requirements
- R1: Byte 0 is bits [127:120] of the 128-bit state, and bytes 4c..4c+3 form column c. Field arithmetic uses the reduction polynomial 0x11b.
- R2: With `dec_mode`=0, each output column byte i equals 02·a_i ^ 03·a_(i+1) ^ a_(i+2) ^ a_(i+3), with indices taken mod 4. For example, column db 13 53 45 becomes 8e 4d a1 bc.
- R3: With `dec_mode`=1, each output column byte i equals 0e·a_i ^ 0b·a_(i+1) ^ 0d·a_(i+2) ^ 09·a_(i+3), with indices taken mod 4.
- R4: In inverse mode, the pre-multiplied byte i is 05·a_i ^ 04·a_(i+2). In forward mode, this stage passes the column through unchanged.
- R5: `state_o` and `out_vld` are registered. They reflect the inputs of the previous clock edge, so the latency is one cycle.
- R6: `out_vld` equals `in_vld` delayed by one cycle. `state_o` updates only on cycles where `in_vld` is high, and holds otherwise.
- R7: An active-low synchronous reset clears `out_vld` and `state_o` to zero.
- R8: Applying forward mode and then inverse mode to any state returns the original state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input state valid |
| dec_mode | input | 1 | 0 = forward mix, 1 = inverse mix |
| state_i | input | 128 | Input state, column-major |
| state_o | output | 128 | Mixed state, registered |
| out_vld | output | 1 | Output valid, one cycle after in_vld |

## Verification
The assertions assume that `in_vld` and `dec_mode` are never X once reset is released. They also assume the state presented with `in_vld` is stable for the sampling edge. The bench drives every input from tasks on the falling clock edge, so these conditions hold. The stimulus varies `in_vld` randomly, which exercises both the hold and the update paths. The round-trip check feeds the registered forward result back in with `dec_mode` set.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
    localparam int BYTE_W  = 8;
    localparam int COL_B   = 4;
    localparam int NCOL    = 4;
    localparam int COL_W   = BYTE_W * COL_B;
    localparam int STATE_W = COL_W * NCOL;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1b;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [COL_W-1:0]  col_t;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               vld;
    } mix_reg_t;

    function automatic byte_t gf_x2(input byte_t b);
        return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? RED_POLY : '0);
    endfunction

    function automatic byte_t gf_x4(input byte_t b);
        return gf_x2(gf_x2(b));
    endfunction
endpackage

// File: rtl/mixcol_premul.sv
module mixcol_premul
    import mixcol_pkg::*;
(
    input  logic  bypass,
    input  col_t  col_i,
    output col_t  col_o
);
    byte_t a [COL_B];
    byte_t e [COL_B];

    generate
        for (genvar i = 0; i < COL_B; i++) begin : g_b
            assign a[i] = col_i[COL_W-1-BYTE_W*i -: BYTE_W];
            // 05*a_i ^ 04*a_(i+2)
            assign e[i] = gf_x4(a[i]) ^ a[i] ^ gf_x4(a[(i+2)%COL_B]);
            assign col_o[COL_W-1-BYTE_W*i -: BYTE_W] = bypass ? a[i] : e[i];
        end
    endgenerate

    // R4: forward mode leaves the column untouched
    always_comb begin
        if (bypass) p_bypass_r4: assert (col_o == col_i);
    end
endmodule

// File: rtl/mixcol_fwd.sv
module mixcol_fwd
    import mixcol_pkg::*;
(
    input  col_t col_i,
    output col_t col_o
);
    byte_t a [COL_B];
    byte_t y [COL_B];

    generate
        for (genvar i = 0; i < COL_B; i++) begin : g_b
            assign a[i] = col_i[COL_W-1-BYTE_W*i -: BYTE_W];
            assign y[i] = gf_x2(a[i])
                        ^ gf_x2(a[(i+1)%COL_B]) ^ a[(i+1)%COL_B]
                        ^ a[(i+2)%COL_B] ^ a[(i+3)%COL_B];
            assign col_o[COL_W-1-BYTE_W*i -: BYTE_W] = y[i];
        end
    endgenerate

    // R2: a zero column mixes to zero
    always_comb begin
        if (col_i == '0) p_zero_fixed_r2: assert (col_o == '0);
    end
endmodule

// File: rtl/mixcol_shared.sv
module mixcol_shared
    import mixcol_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic               dec_mode,
    input  logic [127:0]       state_i,
    output logic [127:0]       state_o,
    output logic               out_vld
);
    logic [STATE_W-1:0] mixed;
    mix_reg_t r_d, r_q;

    generate
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            col_t pre;
            mixcol_premul u_pre (
                .bypass (!dec_mode),
                .col_i  (state_i[STATE_W-1-COL_W*c -: COL_W]),
                .col_o  (pre)
            );
            mixcol_fwd u_fwd (
                .col_i (pre),
                .col_o (mixed[STATE_W-1-COL_W*c -: COL_W])
            );
        end
    endgenerate

    always_comb begin
        r_d     = r_q;
        r_d.vld = in_vld;
        if (in_vld) r_d.state = mixed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign out_vld = r_q.vld;

    p_vld_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_vld_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(state_o));
    p_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && state_i == '0) |=> state_o == '0);
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && state_o == '0));
endmodule

// File: tb/test_mixcol_shared.sv
module test_mixcol_shared;
    logic clk = 0, rst_n = 0, in_vld = 0, dec_mode = 0;
    logic [127:0] state_i = '0;
    logic [127:0] state_o;
    logic out_vld;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mixcol_shared i_mixcol_shared (.clk, .rst_n, .in_vld, .dec_mode,
        .state_i, .state_o, .out_vld);

    function automatic logic [7:0] xt(input logic [7:0] b);
        return {b[6:0],1'b0} ^ (b[7] ? 8'h1b : 8'h00);
    endfunction
    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] k);
        logic [7:0] r = 0, p = a;
        for (int j = 0; j < 8; j++) begin
            if (k[j]) r ^= p;
            p = xt(p);
        end
        return r;
    endfunction
    function automatic logic [127:0] ref_mix(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        logic [7:0] k0, k1, k2, k3;
        k0 = inv ? 8'h0e : 8'h02; k1 = inv ? 8'h0b : 8'h03;
        k2 = inv ? 8'h0d : 8'h01; k3 = inv ? 8'h09 : 8'h01;
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 4; i++)
                o[127-8*(4*c+i) -: 8] =
                    gm(s[127-8*(4*c+i) -: 8], k0) ^
                    gm(s[127-8*(4*c+(i+1)%4) -: 8], k1) ^
                    gm(s[127-8*(4*c+(i+2)%4) -: 8], k2) ^
                    gm(s[127-8*(4*c+(i+3)%4) -: 8], k3);
        return o;
    endfunction

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] s, input bit inv, input bit v);
        @(negedge clk);
        state_i = s; dec_mode = inv; in_vld = v;
        @(negedge clk);
        in_vld = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] s, prev, fw;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        state_i = '1; in_vld = 1;
        @(negedge clk);
        // R7 reset state
        chk("R7", {127'(state_o), out_vld}, '0);
        in_vld = 0;
        rst_n = 1;
        // R2 known column in all columns, R1 byte order
        s = {4{32'hdb135345}};
        apply(s, 0, 1);
        chk("R1_R2", state_o, {4{32'h8e4da1bc}});
        chk("R5", 128'(out_vld), 128'(1)); // R5 latency one
        // R3 inverse of known output
        apply({4{32'h8e4da1bc}}, 1, 1);
        chk("R3_R4", state_o, {4{32'hdb135345}});
        chk("R6", 128'(out_vld), 128'(1));
        // R6 hold when in_vld low
        prev = state_o;
        apply(128'h0123456789abcdef0011223344556677, 0, 0);
        chk("R6", {state_o[127:1], out_vld}, {prev[127:1], 1'b0});
        // directed corners
        apply('1, 0, 1);      chk("R2", state_o, ref_mix('1, 0));
        apply('1, 1, 1);      chk("R3", state_o, ref_mix('1, 1));
        apply({16{8'h80}}, 1, 1); chk("R4", state_o, ref_mix({16{8'h80}}, 1));
        // random
        for (int n = 0; n < 200; n++) begin
            bit inv, v;
            s = {$urandom, $urandom, $urandom, $urandom};
            inv = $urandom_range(0, 1);
            v = $urandom_range(0, 3) != 0;
            prev = state_o;
            apply(s, inv, v);
            if (v) chk(inv ? "R3" : "R2", state_o, ref_mix(s, inv));
            else   chk("R6", state_o, prev);
        end
        // R8 round trip
        for (int n = 0; n < 50; n++) begin
            s = {$urandom, $urandom, $urandom, $urandom};
            apply(s, 0, 1);
            fw = state_o;
            apply(fw, 1, 1);
            chk("R8", state_o, s);
        end
        // R7 reset again mid-run
        @(negedge clk); rst_n = 0; in_vld = 1;
        @(negedge clk);
        chk("R7", {state_o[127:1], out_vld}, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule